// File: doc/BRIEF.md
# Shared Interrupt Vector Register

This block holds the 8-bit interrupt vector shared by the two channels of a dual-channel serial controller. Software can write or read the vector through the register address of either channel, and both addresses reach the same storage. During an interrupt-acknowledge cycle the block drives the vector onto the data bus so the processor can use it as a pointer to a service routine.

A status-modifies-vector option changes what the bus sees. When the option is set, the low three bits returned on a read or an acknowledge are replaced by a code for the most urgent interrupt pending across both channels at that moment. The upper five bits always come from storage. If nothing is pending, the stored low bits pass through unchanged. Only the hardware reset loads the vector with 0Fh. The interrupt sources themselves are outside this block and arrive as level lines.

Top module: `irq_vector_reg`

## Requirements
- R1: A cycle with `rst` high loads the stored vector with 0Fh. A read after reset with the option clear returns 0Fh.
- R2: A write strobe on the channel A address (`wr_a`) stores `wdata`. A read in any later cycle returns the new value.
- R3: A write strobe on the channel B address (`wr_b`) stores into the same register. A read through the channel A address then returns it, and a read through the channel B address returns a value written via channel A.
- R4: A read through either channel's address (`rd_a`, `rd_b`) and an acknowledge (`iack`) each drive the same vector value, with `data_oe` high.
- R5: With `stat_vec` low, reads and acknowledges return exactly the stored value, whatever interrupts are pending.
- R6: With `stat_vec` high, bits 7..3 of `rdata` always equal the stored bits 7..3.
- R7: With `stat_vec` high and at least one source pending, bits 2..0 give the code of the winning source. Source lines are indexed as follows: bit 3 is receive special condition, bit 2 is receive character available, bit 1 is transmit buffer empty, and bit 0 is external/status change. A channel B source with bit index k returns code k. A channel A source with bit index k returns code 4+k.
- R8: Priority is fixed. Every channel A source outranks every channel B source. Within a channel, a higher bit index outranks a lower one.
- R9: With `stat_vec` high and no source pending, bits 2..0 return the stored low bits.
- R10: With no read or acknowledge strobe, `data_oe` is low and `rdata` is 00h.
- R11: When a read and a write fall in the same cycle, the read returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_a | input | 1 | Write strobe, vector address in channel A space |
| wr_b | input | 1 | Write strobe, vector address in channel B space |
| rd_a | input | 1 | Read strobe, vector address in channel A space |
| rd_b | input | 1 | Read strobe, vector address in channel B space |
| iack | input | 1 | Interrupt-acknowledge strobe |
| wdata | input | 8 | Write data |
| stat_vec | input | 1 | Status-modifies-vector option |
| pend_a | input | 4 | Channel A pending sources (bit 3 highest) |
| pend_b | input | 4 | Channel B pending sources (bit 3 highest) |
| rdata | output | 8 | Vector driven on read or acknowledge, 00h otherwise |
| data_oe | output | 1 | High while a read or acknowledge drives `rdata` |

## Verification
Directed cases raise each of the eight source lines alone, which separates every code and the channel offset. Pairs of lines then tell the channel ordering apart from the within-channel ordering. Reads with the option clear while sources are pending show that status leaks only when the option is set. Reads with the option set and nothing pending show the stored low bits passing through. Random cycles mix writes through both addresses, reads, acknowledges, same-cycle read and write, and random pending patterns against a bench model of the vector. This exposes any mix-up between the two write paths or any stale read-back.

// File: rtl/vecreg_pkg.sv
package vecreg_pkg;

    localparam int VEC_W      = 8;
    localparam int SRC_PER_CH = 4;
    localparam int NUM_CH     = 2;
    localparam int NUM_SRC    = NUM_CH * SRC_PER_CH;
    localparam int CODE_W     = $clog2(NUM_SRC);

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Source bit positions inside one channel's pending bundle
    typedef enum int {
        SRC_EXT_STAT = 0,
        SRC_TX_EMPTY = 1,
        SRC_RX_AVAIL = 2,
        SRC_RX_SPCL  = 3
    } src_idx_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_IACK = 2'd2
    } bus_op_e;

    typedef struct packed {
        logic  hit;
        code_t code;
    } prio_t;

    // Splice a priority code into the low bits of a vector
    function automatic vec_t splice_code(vec_t base, code_t code);
        vec_t r;
        r = base;
        r[CODE_W-1:0] = code;
        return r;
    endfunction

endpackage

// File: rtl/vecreg_store.sv
module vecreg_store
    import vecreg_pkg::*;
#(
    parameter vec_t RESET_VALUE = vec_t'(8'h0F)
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  vec_t wdata,
    output vec_t vec_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= RESET_VALUE;
        end else if (wr_en) begin
            vec_q <= wdata;
        end
    end

endmodule

// File: rtl/vecreg_prio.sv
module vecreg_prio
    import vecreg_pkg::*;
(
    input  src_vec_t req,
    output prio_t    result
);

    // Ripple chain from lowest index upward: a later stage overrides,
    // so the highest set index wins.
    logic  hit_c  [NUM_SRC+1];
    code_t code_c [NUM_SRC+1];

    assign hit_c[0]  = 1'b0;
    assign code_c[0] = '0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_stage
        assign hit_c[i+1]  = req[i] | hit_c[i];
        assign code_c[i+1] = req[i] ? code_t'(i) : code_c[i];
    end

    assign result.hit  = hit_c[NUM_SRC];
    assign result.code = code_c[NUM_SRC];

endmodule

// File: rtl/vecreg_merge.sv
module vecreg_merge
    import vecreg_pkg::*;
(
    input  vec_t    vec_q,
    input  prio_t   prio,
    input  logic    stat_vec,
    input  bus_op_e op,
    output vec_t    rdata,
    output logic    data_oe
);

    vec_t shown;

    always_comb begin
        if (stat_vec && prio.hit) begin
            shown = splice_code(vec_q, prio.code);
        end else begin
            shown = vec_q;
        end
    end

    always_comb begin
        unique case (op)
            OP_READ, OP_IACK: begin
                rdata   = shown;
                data_oe = 1'b1;
            end
            default: begin
                rdata   = '0;
                data_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg
    import vecreg_pkg::*;
#(
    parameter vec_t RESET_VALUE = vec_t'(8'h0F)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_a,
    input  logic                  wr_b,
    input  logic                  rd_a,
    input  logic                  rd_b,
    input  logic                  iack,
    input  logic [VEC_W-1:0]      wdata,
    input  logic                  stat_vec,
    input  logic [SRC_PER_CH-1:0] pend_a,
    input  logic [SRC_PER_CH-1:0] pend_b,
    output logic [VEC_W-1:0]      rdata,
    output logic                  data_oe
);

    vec_t     vec_q;
    src_vec_t req;
    prio_t    prio;
    bus_op_e  op;

    // Channel A occupies the upper code range so it outranks channel B
    assign req = {pend_a, pend_b};

    always_comb begin
        if (iack) begin
            op = OP_IACK;
        end else if (rd_a || rd_b) begin
            op = OP_READ;
        end else begin
            op = OP_IDLE;
        end
    end

    vecreg_store #(
        .RESET_VALUE(RESET_VALUE)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_a | wr_b),
        .wdata (wdata),
        .vec_q (vec_q)
    );

    vecreg_prio u_prio (
        .req    (req),
        .result (prio)
    );

    vecreg_merge u_merge (
        .vec_q    (vec_q),
        .prio     (prio),
        .stat_vec (stat_vec),
        .op       (op),
        .rdata    (rdata),
        .data_oe  (data_oe)
    );

endmodule

// File: rtl/vecreg_chk.sv
module vecreg_chk
    import vecreg_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_a,
    input logic                  wr_b,
    input logic                  rd_a,
    input logic                  rd_b,
    input logic                  iack,
    input logic [VEC_W-1:0]      wdata,
    input logic                  stat_vec,
    input logic [SRC_PER_CH-1:0] pend_a,
    input logic [SRC_PER_CH-1:0] pend_b,
    input logic [VEC_W-1:0]      rdata,
    input logic                  data_oe,
    input vec_t                  vec_q
);

    logic strobe;
    assign strobe = rd_a | rd_b | iack;

    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (vec_q == vec_t'(8'h0F)));

    p_write_store_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_a || wr_b) |=> (vec_q == $past(wdata)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_a || wr_b) |=> $stable(vec_q));

    p_drive_r4: assert property (@(posedge clk) disable iff (rst)
        strobe |-> data_oe);

    p_plain_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe && !stat_vec) |-> (rdata == vec_q));

    p_upper_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (rdata[VEC_W-1:CODE_W] == vec_q[VEC_W-1:CODE_W]));

    p_chan_a_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (strobe && stat_vec && (pend_a != '0)) |-> rdata[CODE_W-1]);

    p_no_pend_r9: assert property (@(posedge clk) disable iff (rst)
        (strobe && stat_vec && pend_a == '0 && pend_b == '0) |-> (rdata == vec_q));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> (!data_oe && rdata == '0));

endmodule

bind irq_vector_reg vecreg_chk u_chk (.*);

// File: tb/irq_vector_reg_test.sv
module irq_vector_reg_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_a, wr_b, rd_a, rd_b, iack, stat_vec;
    logic [7:0] wdata;
    logic [3:0] pend_a, pend_b;
    logic [7:0] rdata;
    logic       data_oe;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model;

    always #4 clk = ~clk;

    irq_vector_reg uut (
        .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b), .rd_a(rd_a),
        .rd_b(rd_b), .iack(iack), .wdata(wdata), .stat_vec(stat_vec),
        .pend_a(pend_a), .pend_b(pend_b), .rdata(rdata), .data_oe(data_oe)
    );

    // Expected read value from the requirements (R5-R9)
    function automatic logic [7:0] exp_read(logic [7:0] v, logic opt,
                                            logic [3:0] pa, logic [3:0] pb);
        logic [7:0] r;
        logic done;
        r = v;
        done = 1'b0;
        if (opt) begin
            for (int k = 3; k >= 0; k--) begin
                if (!done && pa[k]) begin r[2:0] = 3'(4 + k); done = 1'b1; end
            end
            for (int k = 3; k >= 0; k--) begin
                if (!done && pb[k]) begin r[2:0] = 3'(k); done = 1'b1; end
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_a = 0; wr_b = 0; rd_a = 0; rd_b = 0; iack = 0;
        wdata = 8'h00; stat_vec = 0; pend_a = 4'h0; pend_b = 4'h0;
    endtask

    // One bus cycle: drive after negedge, sample before posedge, update model
    task automatic bus_cycle(input logic wa, input logic wb, input logic ra,
                             input logic rb, input logic ia, input logic [7:0] wd,
                             input logic opt, input logic [3:0] pa,
                             input logic [3:0] pb, input string req);
        logic [7:0] e;
        @(negedge clk);
        wr_a = wa; wr_b = wb; rd_a = ra; rd_b = rb; iack = ia;
        wdata = wd; stat_vec = opt; pend_a = pa; pend_b = pb;
        #3;
        if (ra || rb || ia) begin
            e = exp_read(model, opt, pa, pb);
            check(rdata == e && data_oe, req, rdata, e);
            check(rdata[7:3] == model[7:3], "R6", rdata, model);
        end else begin
            check(rdata == 8'h00 && !data_oe, "R10", rdata, 8'h00);
        end
        if (wa || wb) model = wd;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model = 8'h0F;

        // R1: reset value, option clear
        bus_cycle(0, 0, 1, 0, 0, 8'h00, 0, 4'h0, 4'h0, "R1");
        bus_cycle(0, 0, 0, 0, 0, 8'h00, 0, 4'h0, 4'h0, "R10");

        // R2: write via A, read via A
        bus_cycle(1, 0, 0, 0, 0, 8'hA5, 0, 4'h0, 4'h0, "R2");
        bus_cycle(0, 0, 1, 0, 0, 8'h00, 0, 4'h0, 4'h0, "R2");
        // R3: read via B returns A's write; write via B, read via A
        bus_cycle(0, 0, 0, 1, 0, 8'h00, 0, 4'h0, 4'h0, "R3");
        bus_cycle(0, 1, 0, 0, 0, 8'h3C, 0, 4'h0, 4'h0, "R3");
        bus_cycle(0, 0, 1, 0, 0, 8'h00, 0, 4'h0, 4'h0, "R3");
        // R4: acknowledge returns the same
        bus_cycle(0, 0, 0, 0, 1, 8'h00, 0, 4'h0, 4'h0, "R4");
        // R5: option clear with everything pending
        bus_cycle(0, 0, 0, 0, 1, 8'h00, 0, 4'hF, 4'hF, "R5");
        // R9: option set, nothing pending (stored low bits 100)
        bus_cycle(0, 0, 1, 0, 0, 8'h00, 1, 4'h0, 4'h0, "R9");

        // R7: each source alone, on a vector with low bits 111
        bus_cycle(1, 0, 0, 0, 0, 8'hF7, 0, 4'h0, 4'h0, "R7");
        for (int k = 0; k < 4; k++) begin
            bus_cycle(0, 0, 0, 0, 1, 8'h00, 1, 4'h0, 4'(1 << k), "R7");
            bus_cycle(0, 0, 1, 0, 0, 8'h00, 1, 4'(1 << k), 4'h0, "R7");
        end

        // R8: channel ordering and within-channel ordering
        bus_cycle(0, 0, 0, 0, 1, 8'h00, 1, 4'b0001, 4'b1000, "R8");
        bus_cycle(0, 0, 0, 0, 1, 8'h00, 1, 4'b0000, 4'b0110, "R8");
        bus_cycle(0, 0, 0, 1, 0, 8'h00, 1, 4'b1010, 4'b1111, "R8");

        // R11: read and write in the same cycle returns the old value
        bus_cycle(1, 0, 1, 0, 0, 8'h5A, 0, 4'h0, 4'h0, "R11");
        bus_cycle(0, 0, 1, 0, 0, 8'h00, 0, 4'h0, 4'h0, "R11");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] sel;
            logic opt;
            logic [3:0] pa, pb;
            string tag;
            sel = 3'($urandom_range(0, 7));
            opt = 1'($urandom);
            pa  = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
            pb  = ($urandom_range(0, 1) == 0) ? 4'($urandom) : 4'h0;
            if (!opt) tag = "R5";
            else if (pa == 0 && pb == 0) tag = "R9";
            else tag = "R8";
            case (sel)
                3'd0: bus_cycle(1, 0, 0, 0, 0, 8'($urandom), opt, pa, pb, "R2");
                3'd1: bus_cycle(0, 1, 0, 0, 0, 8'($urandom), opt, pa, pb, "R3");
                3'd2: bus_cycle(0, 0, 1, 0, 0, 8'h00, opt, pa, pb, tag);
                3'd3: bus_cycle(0, 0, 0, 1, 0, 8'h00, opt, pa, pb, tag);
                3'd4: bus_cycle(0, 0, 0, 0, 1, 8'h00, opt, pa, pb, tag);
                3'd5: bus_cycle(0, 1, 0, 0, 1, 8'($urandom), opt, pa, pb, "R11");
                3'd6: bus_cycle(1, 1, 0, 1, 0, 8'($urandom), opt, pa, pb, "R11");
                default: bus_cycle(0, 0, 0, 0, 0, 8'($urandom), opt, pa, pb, "R10");
            endcase
        end

        // R1 again: hardware reset mid-run restores 0Fh
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        rst = 0;
        model = 8'h0F;
        bus_cycle(0, 0, 0, 1, 0, 8'h00, 0, 4'h0, 4'h0, "R1");

        @(negedge clk);
        idle_inputs();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule